// File: doc/BRIEF.md
# DTMF Tone Burst Sequencer

This block decides when a dual-tone generator is keyed and which of its two frequency groups (row or low group, column or high group) is switched on. It does not synthesize sine waves and does not look up frequencies. It only produces the enables and their timing. Software writes a digit code to the transmit register, and the block sees that write as a one-cycle strobe.

In burst mode, selected by an active-low control bit, each accepted write produces a tone of fixed length. A silence of the same length follows the tone. A one-cycle ready pulse then tells software that the next digit may be written. With call-progress timing enabled at the moment of the write, the tone and the silence are both twice as long. With burst mode off, the tone is keyed directly by a key input for as long as software holds it. In that mode there is no automatic silence and no ready event.

The steering bits choose between two outputs. Dual tone enables both groups. Single tone enables exactly one group, picked by a column/row bit.

Top module: `toneBurstSeq`

## Requirements
- R1: After reset, toneEn, rowEn, colEn and readyPulse are all 0.
- R2: With burstModeN=0, a digitWr accepted at a clock edge makes toneEn 1 from that edge for exactly BURST_CYCLES cycles, when callProg=0 at the write.
- R3: After the tone, toneEn stays 0 for a silence of the same length as the tone that preceded it.
- R4: readyPulse is 1 for exactly one cycle, starting at the edge that ends the silence, which is 2×(tone length) edges after the write edge. Its value is 0 at every other time.
- R5: If callProg=1 at the accepted write, both the tone and the silence last 2×BURST_CYCLES cycles. The value of callProg at later times has no effect on a burst already running.
- R6: With burstModeN=1, toneEn takes the value of keyOn one cycle later. A digitWr in this mode produces no tone and no readyPulse.
- R7: With singleTone=0, rowEn and colEn both equal toneEn.
- R8: With singleTone=1, colSel=0 drives rowEn only and colSel=1 drives colEn only. Both are gated by toneEn.
- R9: A digitWr that arrives during a tone or a silence is ignored. The running burst keeps its timing, only one readyPulse results, and no new burst follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| burstModeN | input | 1 | 0 selects timed bursts, 1 selects key-driven tone |
| singleTone | input | 1 | 0 dual tone, 1 single group |
| colSel | input | 1 | With singleTone=1: 0 row group, 1 column group |
| callProg | input | 1 | Doubles burst and silence length when 1 at the write |
| keyOn | input | 1 | Tone key in non-burst mode |
| digitWr | input | 1 | One-cycle transmit register write strobe |
| toneEn | output | 1 | Tone generator keyed |
| rowEn | output | 1 | Row (low group) oscillator enable |
| colEn | output | 1 | Column (high group) oscillator enable |
| readyPulse | output | 1 | One-cycle transmitter-ready pulse |

## Verification
The bench compares every cycle of a burst against a cycle-accurate expectation. It therefore catches a counter that is off by one, which would show up as a tone or silence one cycle long or short, or as a ready pulse that comes early or is two cycles wide. Call-progress bursts are run both with the bit held high and with it dropped mid-burst. A design that sampled the bit live, or doubled only one phase, would move the ready pulse. Writes are injected during both the tone and the silence, where a design that restarted would stretch the burst or issue a second ready. A write in non-burst mode is also checked, since a design that timed it would raise ready. The steering combinations are checked in both modes, so that an inverted row/column select or an enable left on during silence is reported.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TONE  = 2'd1,
    ST_PAUSE = 2'd2
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;    // latch length, clear counter, key tone
    logic inc;      // advance phase counter
    logic toPause;  // unkey tone, clear counter
    logic done;     // silence finished, raise ready
    logic freeRun;  // non-burst: follow key input
  } seqStrobe_t;

endpackage

// File: rtl/tbs_ctrl.sv
module tbs_ctrl
  import tbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       burstModeN,
  input  logic       digitWr,
  input  logic       cntDone,
  output seqStrobe_t strobe
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        strobe.freeRun = burstModeN;
        if (!burstModeN && digitWr) begin
          strobe.start = 1'b1;
          stateNext    = ST_TONE;
        end
      end
      ST_TONE: begin
        if (cntDone) begin
          strobe.toPause = 1'b1;
          stateNext      = ST_PAUSE;
        end else begin
          strobe.inc = 1'b1;
        end
      end
      ST_PAUSE: begin
        if (cntDone) begin
          strobe.done = 1'b1;
          stateNext   = ST_IDLE;
        end else begin
          strobe.inc = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R2
  tone_leads_pause_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_TONE |=> state != ST_IDLE);

  // R9
  pause_no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PAUSE |=> state != ST_TONE);

  // R6
  free_no_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && burstModeN) |=> state == ST_IDLE);

endmodule

// File: rtl/tbs_datapath.sv
module tbs_datapath
  import tbs_pkg::*;
#(
  parameter int BURST_CYCLES = 50000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       callProg,
  input  logic       keyOn,
  input  logic       singleTone,
  input  logic       colSel,
  output logic       cntDone,
  output logic       toneEn,
  output logic       rowEn,
  output logic       colEn,
  output logic       readyPulse
);

  localparam int CNT_W = $clog2(2 * BURST_CYCLES + 1);
  localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(BURST_CYCLES);
  localparam logic [CNT_W-1:0] DBL_LEN  = CNT_W'(2 * BURST_CYCLES);

  logic [CNT_W-1:0] phaseCnt;
  logic [CNT_W-1:0] phaseLen;
  logic             burstTone;
  logic             freeTone;
  logic             readyReg;

  // one terminal count shared by tone and silence phases
  assign cntDone = (phaseCnt == phaseLen - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      phaseLen <= BASE_LEN;
    end else if (strobe.start) begin
      phaseCnt <= '0;
      phaseLen <= callProg ? DBL_LEN : BASE_LEN;
    end else if (strobe.toPause) begin
      phaseCnt <= '0;
    end else if (strobe.inc) begin
      phaseCnt <= phaseCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstTone <= 1'b0;
      freeTone  <= 1'b0;
      readyReg  <= 1'b0;
    end else begin
      if (strobe.start)        burstTone <= 1'b1;
      else if (strobe.toPause) burstTone <= 1'b0;
      freeTone <= strobe.freeRun & keyOn;
      readyReg <= strobe.done;
    end
  end

  assign toneEn     = burstTone | freeTone;
  assign readyPulse = readyReg;

  // group steering: dual enables both, single picks one
  always_comb begin
    rowEn = toneEn & (~singleTone | ~colSel);
    colEn = toneEn & (~singleTone |  colSel);
  end

  // R4
  ready_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |=> !readyPulse);

  // R3
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyPulse |-> !toneEn);

  // R8
  steer_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (toneEn && singleTone) |-> (rowEn != colEn));

  // R7
  steer_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !toneEn |-> !(rowEn || colEn));

  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseCnt < phaseLen);

endmodule

// File: rtl/toneBurstSeq.sv
module toneBurstSeq
  import tbs_pkg::*;
#(
  parameter int BURST_CYCLES = 50000
) (
  input  logic clk,
  input  logic rstN,
  input  logic burstModeN,
  input  logic singleTone,
  input  logic colSel,
  input  logic callProg,
  input  logic keyOn,
  input  logic digitWr,
  output logic toneEn,
  output logic rowEn,
  output logic colEn,
  output logic readyPulse
);

  seqStrobe_t strobe;
  logic       cntDone;

  tbs_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .burstModeN (burstModeN),
    .digitWr    (digitWr),
    .cntDone    (cntDone),
    .strobe     (strobe)
  );

  tbs_datapath #(.BURST_CYCLES(BURST_CYCLES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .callProg   (callProg),
    .keyOn      (keyOn),
    .singleTone (singleTone),
    .colSel     (colSel),
    .cntDone    (cntDone),
    .toneEn     (toneEn),
    .rowEn      (rowEn),
    .colEn      (colEn),
    .readyPulse (readyPulse)
  );

endmodule

// File: tb/toneBurstSeq_tb.sv
module toneBurstSeq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LEN = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstModeN = 1'b1, singleTone = 1'b0, colSel = 1'b0;
  logic callProg = 1'b0, keyOn = 1'b0, digitWr = 1'b0;
  logic toneEn, rowEn, colEn, readyPulse;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  toneBurstSeq #(.BURST_CYCLES(LEN)) dut_i (
    .clk(clk), .rstN(rstN), .burstModeN(burstModeN), .singleTone(singleTone),
    .colSel(colSel), .callProg(callProg), .keyOn(keyOn), .digitWr(digitWr),
    .toneEn(toneEn), .rowEn(rowEn), .colEn(colEn), .readyPulse(readyPulse)
  );

  // vector: {singleTone, colSel, keyOn, expTone, expRow, expCol}, non-burst mode
  localparam int NVEC = 8;
  localparam logic [5:0] VECS [NVEC] = '{
    6'b001_111, 6'b000_000, 6'b101_110, 6'b111_101,
    6'b011_111, 6'b100_000, 6'b110_000, 6'b001_111
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // run one burst; inject writes at indices injA/injB; drop callProg at index dropAt
  task automatic runBurst(input int len, input int injA, input int injB,
                          input int dropAt, input string req);
    digitWr = 1'b1;
    @(negedge clk);
    digitWr = 1'b0;
    for (int i = 0; i <= 2 * len + 3; i++) begin
      bit expTone = (i < len);
      bit expRdy  = (i == 2 * len);
      bit expRow  = expTone & (~singleTone | ~colSel);
      bit expCol  = expTone & (~singleTone | colSel);
      check(toneEn == expTone, {req, " tone"}, toneEn, expTone);
      check(readyPulse == expRdy, {req, " ready"}, readyPulse, expRdy);
      check(rowEn == expRow, {req, " row R8"}, rowEn, expRow);
      check(colEn == expCol, {req, " col R8"}, colEn, expCol);
      digitWr  = (i == injA || i == injB);
      if (i == dropAt) callProg = 1'b0;
      @(negedge clk);
      digitWr = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 1);
    check({toneEn, rowEn, colEn, readyPulse} == 4'b0, "R1 reset", {toneEn, rowEn, colEn, readyPulse}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check({toneEn, rowEn, colEn, readyPulse} == 4'b0, "R1 after release", {toneEn, rowEn, colEn, readyPulse}, 0);

    // R6 R7 R8 table in non-burst mode
    burstModeN = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      {singleTone, colSel, keyOn} = VECS[v][5:3];
      @(negedge clk);
      check(toneEn == VECS[v][2], "R6 key tone", toneEn, VECS[v][2]);
      check(rowEn == VECS[v][1], "R7 R8 row", rowEn, VECS[v][1]);
      check(colEn == VECS[v][0], "R7 R8 col", colEn, VECS[v][0]);
    end
    keyOn = 1'b0;
    @(negedge clk);

    // R6 write in non-burst mode: no tone, no ready
    digitWr = 1'b1;
    @(negedge clk);
    digitWr = 1'b0;
    for (int i = 0; i < 2 * LEN + 3; i++) begin
      check(!toneEn && !readyPulse, "R6 write ignored", {toneEn, readyPulse}, 0);
      @(negedge clk);
    end

    // R2 R3 R4 basic dual-tone burst
    burstModeN = 1'b0; singleTone = 1'b0; colSel = 1'b0;
    @(negedge clk);
    runBurst(LEN, -1, -1, -1, "R2 R3 R4 R7 dual");

    // R8 single row and single column bursts
    singleTone = 1'b1; colSel = 1'b0;
    runBurst(LEN, -1, -1, -1, "R8 single row");
    colSel = 1'b1;
    runBurst(LEN, -1, -1, -1, "R8 single col");

    // R5 call-progress doubling, held and dropped mid-burst
    singleTone = 1'b0; callProg = 1'b1;
    runBurst(2 * LEN, -1, -1, -1, "R5 doubled");
    callProg = 1'b1;
    runBurst(2 * LEN, -1, -1, 3, "R5 latched");

    // R9 writes during tone and during silence are ignored
    runBurst(LEN, 2, LEN + 1, -1, "R9 busy writes");
    runBurst(LEN, LEN - 1, 2 * LEN - 1, -1, "R9 edge writes");

    summary();
  end

endmodule